// File: doc/BRIEF.md
# Transition-Encoded Line Transmitter With Refresh

This block is the transmit half of a multi-line, one-direction logic link across an isolation boundary, kept wholly digital. Each input line is synchronized and compared against the level last reported for it. A rising transition turns into a set-high message and a falling one into a set-low message. Each message carries the line index and the new level, and is marked by a one-cycle valid strobe.

Edge messages alone cannot recover from a lost message. A per-line refresh timer therefore resends the present level of any line that has had no message for a full refresh period. Messages are held back until a power-good hold-off has elapsed. A side enable freezes the reported state. Whenever the block becomes active, at the end of hold-off or when the enable returns, it announces every line once. At most one message leaves per clock. Edge traffic wins over refresh traffic, and lower line numbers win within each class.

All inputs except `rst_ni` are sampled on `clk_i`. `line_i` may be asynchronous. `enable_i` and `pwr_good_i` are taken to be synchronous to `clk_i`.

Top module: `edge_line_tx`

## Requirements
- R1: After reset, and after `pwr_good_i` rises, `msg_valid_o` stays low while `pwr_good_i` has been high for fewer than HOLDOFF_CYC consecutive clock edges.
- R2: Dropping `pwr_good_i` stops messages from the next clock edge on. It also restarts the full hold-off count, which begins again once `pwr_good_i` returns high.
- R3: When a line changes while the block is active, a message with `msg_line_o` equal to the line number goes out. `msg_level_o` is 1 for a rise and 0 for a fall. `msg_valid_o` is high in the cycle that follows the 4th rising clock edge, counting from the edge that first samples the new input value, provided no earlier edge message is still waiting.
- R4: A line with no other traffic is resent with its current level every REFRESH_CYC+1 cycles. Waiting for arbitration may add up to 2*NUM_LINES further cycles.
- R5: Any message on a line restarts that line's refresh period. No refresh for a line goes out fewer than REFRESH_CYC+1 cycles after the previous message on the same line.
- R6: At most one message is issued per cycle. Pending edge messages always win over pending refresh messages. Among lines of the same class, the lowest index goes first, so lines that change together come out on consecutive cycles in ascending index order.
- R7: While `enable_i` is low, no message is issued from the next clock edge on, and neither edges nor refresh produce traffic. The last reported level of each line is kept.
- R8: When the block becomes active, through `enable_i` rising or the hold-off completing, it sends one message per line on consecutive cycles, lines 0 up to NUM_LINES-1, each carrying the line's current level. After `enable_i` rises, line 0 is valid in the cycle after the second rising edge. After the hold-off completes, line 0 is valid two edges after the edge on which the count reaches HOLDOFF_CYC.
- R9: A change that lasts a single clock cycle on an otherwise quiet link produces a set-high and a set-low message for that line, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Logic lines to be transmitted |
| enable_i | input | 1 | Side enable; low freezes the transmitter |
| pwr_good_i | input | 1 | Supply good; low restarts the hold-off |
| msg_valid_o | output | 1 | Message strobe, one cycle per message |
| msg_line_o | output | IDX_W | Line index of the message |
| msg_level_o | output | 1 | 1 = set-high, 0 = set-low |

## Verification
A corrupted reported level for a line appears on the ports as a missing or extra edge message within four cycles of the next input change. If no input changes, it appears as a refresh carrying the wrong level no later than one refresh period afterwards. A timer that fails to restart shows up as a refresh arriving too soon after an edge message. A stuck pending bit shows up as a message repeating out of order. A wrong hold-off or enable state shows up immediately, as traffic during a quiet window or as a missing announcement sweep at the exact expected cycle.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_EDGE    = 2'd1,
    KIND_REFRESH = 2'd2
  } msg_kind_e;

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ltx_sync.sv
module ltx_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  initial begin
    stages_min_chk: assert (STAGES >= 2);
  end

endmodule

// File: rtl/ltx_holdoff.sv
module ltx_holdoff #(
  parameter int HOLDOFF_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic done_o
);

  localparam int CNT_W = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLDOFF_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!pwr_good_i)    cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_MAX);

  // R1
  holdoff_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(pwr_good_i));

  // R2
  holdoff_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !done_o);

endmodule

// File: rtl/ltx_refresh.sv
module ltx_refresh #(
  parameter int NUM_LINES   = 5,
  parameter int REFRESH_CYC = 500
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic [NUM_LINES-1:0] sent_i,
  output logic [NUM_LINES-1:0] due_o
);

  localparam int TMR_W = $clog2(REFRESH_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH_CYC - 1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     tmr_q <= '0;
      else if (!active_i || sent_i[g]) tmr_q <= '0;
      else if (tmr_q == TMR_LAST)      tmr_q <= '0;
      else                             tmr_q <= tmr_q + 1'b1;
    end

    assign due_o[g] = active_i && !sent_i[g] && (tmr_q == TMR_LAST);

    // R5
    tmr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sent_i[g] |=> (tmr_q == '0));
  end

endmodule

// File: rtl/ltx_arbiter.sv
module ltx_arbiter
  import ltx_pkg::*;
#(
  parameter int NUM_LINES = 5,
  parameter int IDX_W     = idx_w(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] edge_pend_i,
  input  logic [NUM_LINES-1:0] ref_pend_i,
  output logic [NUM_LINES-1:0] grant_o,
  output logic [IDX_W-1:0]     idx_o,
  output msg_kind_e            kind_o
);

  logic                 use_edge;
  logic [NUM_LINES-1:0] pool;

  assign use_edge = |edge_pend_i;
  assign pool     = use_edge ? edge_pend_i : ref_pend_i;
  assign grant_o  = pool & (~pool + NUM_LINES'(1));

  always_comb begin
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (grant_o[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    if (grant_o == '0)  kind_o = KIND_NONE;
    else if (use_edge)  kind_o = KIND_EDGE;
    else                kind_o = KIND_REFRESH;
  end

  // R6
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R6
  edge_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_pend_i) |-> (|(grant_o & edge_pend_i)));

endmodule

// File: rtl/edge_line_tx.sv
module edge_line_tx
  import ltx_pkg::*;
#(
  parameter int NUM_LINES   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int REFRESH_CYC = 500,
  parameter int HOLDOFF_CYC = 3000,
  parameter int IDX_W       = idx_w(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 enable_i,
  input  logic                 pwr_good_i,
  output logic                 msg_valid_o,
  output logic [IDX_W-1:0]     msg_line_o,
  output logic                 msg_level_o
);

  logic [NUM_LINES-1:0] line_s;
  logic [NUM_LINES-1:0] known_q;
  logic [NUM_LINES-1:0] pend_edge_q, pend_ref_q;
  logic [NUM_LINES-1:0] edge_hit, due, grant;
  logic [IDX_W-1:0]     grant_idx;
  msg_kind_e            grant_kind;
  logic                 holdoff_done, active, active_q, start;

  ltx_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  ltx_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) i_holdoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .done_o    (holdoff_done)
  );

  assign active   = holdoff_done && pwr_good_i && enable_i;
  assign start    = active && !active_q;
  assign edge_hit = active ? (line_s ^ known_q) : '0;

  ltx_refresh #(.NUM_LINES(NUM_LINES), .REFRESH_CYC(REFRESH_CYC)) i_refresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .sent_i  (grant),
    .due_o   (due)
  );

  ltx_arbiter #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_pend_i(pend_edge_q),
    .ref_pend_i (pend_ref_q),
    .grant_o    (grant),
    .idx_o      (grant_idx),
    .kind_o     (grant_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      known_q     <= '0;
      pend_edge_q <= '0;
      pend_ref_q  <= '0;
    end else begin
      active_q <= active;
      if (active) begin
        known_q     <= line_s;
        // a fresh edge on a granted line re-arms it
        pend_edge_q <= (pend_edge_q & ~grant) | edge_hit | {NUM_LINES{start}};
        pend_ref_q  <= (pend_ref_q & ~grant) | due;
      end else begin
        pend_edge_q <= '0;
        pend_ref_q  <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_line_o  <= '0;
      msg_level_o <= 1'b0;
    end else begin
      msg_valid_o <= active && (grant != '0);
      msg_line_o  <= grant_idx;
      msg_level_o <= |(grant & known_q);
    end
  end

  // R7
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !msg_valid_o);

  // R1
  quiet_in_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !holdoff_done |=> !msg_valid_o);

  // R6
  refresh_yields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_kind == KIND_REFRESH) |-> (pend_edge_q == '0));

  // R3
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (int'(msg_line_o) < NUM_LINES));

endmodule

// File: tb/test_edge_line_tx.sv
module test_edge_line_tx;
  localparam int N  = 5;
  localparam int RC = 500;
  localparam int HC = 3000;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = 5'b10010;
  logic          en = 1'b1;
  logic          pg = 1'b1;
  logic          msg_valid;
  logic [IW-1:0] msg_line;
  logic          msg_level;

  edge_line_tx #(.NUM_LINES(N), .REFRESH_CYC(RC), .HOLDOFF_CYC(HC)) i_edge_line_tx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (lines),
    .enable_i   (en),
    .pwr_good_i (pg),
    .msg_valid_o(msg_valid),
    .msg_line_o (msg_line),
    .msg_level_o(msg_level)
  );

  always #10 clk = ~clk;

  typedef struct {int line; int level; int at; string req;} exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0, errors = 0;
  logic [N-1:0] model = 5'b10010, prev_model = 5'b10010;
  int chg_cyc[N], last_msg[N], ref_cnt[N];
  bit quiet = 1'b0;
  int quiet_until = 0;
  string quiet_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      chg_cyc[i] = -100; last_msg[i] = -1; ref_cnt[i] = 0;
    end
  end

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (msg_valid) begin
        int l, v;
        exp_t e;
        l = int'(msg_line);
        v = int'(msg_level);
        if (quiet || cyc <= quiet_until) begin
          chk(1'b0, quiet_req, "message in quiet window, line", l, -1);
        end else if (q.size() > 0 && q[0].line == l && q[0].level == v) begin
          e = q.pop_front();
          chk(cyc == e.at, e.req, "message cycle", cyc, e.at);
        end else if (l < N) begin
          bit lvl_ok;
          lvl_ok = (v == int'(model[l])) ||
                   ((cyc - chg_cyc[l] < 8) && (v == int'(prev_model[l])));
          chk(lvl_ok, "R4", "refresh level", v, int'(model[l]));
          if (last_msg[l] >= 0) begin
            chk(cyc - last_msg[l] >= RC + 1, "R5", "refresh gap min", cyc - last_msg[l], RC + 1);
            chk(cyc - last_msg[l] <= RC + 1 + 2 * N, "R4", "refresh gap max", cyc - last_msg[l], RC + 1 + 2 * N);
          end
          ref_cnt[l]++;
        end else begin
          chk(1'b0, "R3", "line index", l, N - 1);
        end
        if (l < N) last_msg[l] = cyc;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  // called at a negedge; drives new line values and queues edge messages
  task automatic drive(logic [N-1:0] nv, string req, bit expect_msgs);
    int k = 0;
    for (int i = 0; i < N; i++) begin
      if (nv[i] != model[i]) begin
        if (expect_msgs) begin
          q.push_back('{i, int'(nv[i]), cyc + 4 + k, req});
          k++;
        end
        prev_model[i] = model[i];
        chg_cyc[i] = cyc;
      end
    end
    model = nv;
    lines = nv;
  endtask

  task automatic expect_sweep(int first_at, string req);
    for (int i = 0; i < N; i++) q.push_back('{i, int'(model[i]), first_at + i, req});
  endtask

  task automatic drain(int limit, string req);
    int n = 0;
    while (q.size() > 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(q.size() == 0, req, "pending expected messages", q.size(), 0);
    q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int m;
    repeat (3) @(negedge clk);
    chk(msg_valid == 1'b0, "R1", "valid during reset", int'(msg_valid), 0);
    rst_n = 1'b1;
    m = cyc;
    quiet_until = m + HC + 1;
    quiet_req = "R1";
    expect_sweep(m + HC + 2, "R8");
    repeat (HC / 2) @(negedge clk);
    chk(msg_valid == 1'b0, "R1", "valid mid hold-off", int'(msg_valid), 0);
    drain(HC, "R8");

    // R3 rise and fall on line 0
    repeat (20) @(negedge clk);
    drive(model | 5'b00001, "R3", 1'b1);
    drain(20, "R3");
    drive(model & 5'b11110, "R3", 1'b1);
    drain(20, "R3");

    // R6 simultaneous changes
    drive(model ^ 5'b01010, "R6", 1'b1);
    drain(20, "R6");
    drive(~model, "R6", 1'b1);
    drain(20, "R6");

    // R9 single-cycle pulse on line 4
    drive(model ^ 5'b10000, "R9", 1'b1);
    @(negedge clk);
    drive(model ^ 5'b10000, "R9", 1'b1);
    drain(20, "R9");

    // R4 idle refresh; R5 edge on line 2 mid-way
    for (int i = 0; i < N; i++) ref_cnt[i] = 0;
    repeat (RC + RC / 2) @(negedge clk);
    drive(model ^ 5'b00100, "R5", 1'b1);
    drain(20, "R5");
    repeat (2 * RC) @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(ref_cnt[i] >= 2, "R4", "refresh count", ref_cnt[i], 2);

    // R7 disable: input changes ignored, no refresh
    @(negedge clk);
    en = 1'b0;
    quiet = 1'b1;
    quiet_req = "R7";
    repeat (5) @(negedge clk);
    drive(model ^ 5'b00001, "R7", 1'b0);
    repeat (10) @(negedge clk);
    drive(model ^ 5'b00001, "R7", 1'b0);
    repeat (5) @(negedge clk);
    drive(model ^ 5'b00100, "R7", 1'b0);
    repeat (RC + 50) @(negedge clk);
    chk(msg_valid == 1'b0, "R7", "valid while disabled", int'(msg_valid), 0);

    // R8 re-enable sweep with current levels
    en = 1'b1;
    quiet = 1'b0;
    expect_sweep(cyc + 2, "R8");
    drain(30, "R8");

    // R2 power-good drop restarts hold-off
    pg = 1'b0;
    quiet = 1'b1;
    quiet_req = "R2";
    repeat (50) @(negedge clk);
    chk(msg_valid == 1'b0, "R2", "valid with power low", int'(msg_valid), 0);
    pg = 1'b1;
    m = cyc;
    quiet = 1'b0;
    quiet_until = m + HC + 1;
    expect_sweep(m + HC + 2, "R2");
    drain(HC + 30, "R2");

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule